// File: doc/BRIEF.md
# Transmit Automatic Level Controller

The controller sets the attenuation of a power-line transmitter from two comparator results on the sensed line-driver peak. One result says the peak is under the low threshold and the other says it is over the high threshold. The peak detector and the comparators sit outside the block. The controller only sees their digital flags, together with a frame-start pulse and a bit-boundary strobe from the transmit framer.

Adaptation happens only at the start of each frame. From `frame_start` the block runs a short adaptation window. Inside it, a quarter-bit timer fires eight evenly spaced step instants across the first two bits. At each instant the flags are sampled, and the 3-bit attenuation code moves by one 3 dB step or stays where it is. After the eighth step, or when the second bit boundary closes the window, the code is frozen until the next frame. The code carries over from frame to frame and returns to 0 dB only on reset.

The sequencer has three states:
- `ST_IDLE`: after reset, until the first frame.
- `ST_ADAPT`: the adaptation window.
- `ST_HOLD`: the code is frozen for the rest of the frame.

Its transitions are:
- `ST_IDLE` to `ST_ADAPT` on `frame_start`.
- `ST_ADAPT` back to `ST_ADAPT` on `frame_start`, which restarts the window.
- `ST_ADAPT` to `ST_HOLD` when the eighth step is applied or the window ends at the second bit strobe.
- `ST_HOLD` to `ST_ADAPT` on `frame_start`.

Top module: `tx_alc_ctrl`

## Requirements
- R1: Counting the edge that samples `frame_start` as edge 0, step instants fall on edges QTR_CYCLES, 2·QTR_CYCLES, … 8·QTR_CYCLES. `atten_code` changes only as a result of a step instant, and the new value is visible just after that edge.
- R2: `atten_code` n means an attenuation of 3·n dB, for n from 0 to 7. At a step instant with `peak_low`=1 and `peak_high`=0, the code drops by one (gain up 3 dB). It saturates at 0 and never wraps.
- R3: At a step instant with `peak_high`=1, the code rises by one (gain down 3 dB). This holds even if `peak_low` is also 1. The code saturates at 7 and never wraps.
- R4: At a step instant with both flags 0, the code is unchanged.
- R5: At most eight step instants occur per frame. After the eighth, the code holds for the rest of the frame whatever the flags and `bit_strobe` do.
- R6: The window also closes at the second `bit_strobe` after `frame_start`, even if fewer than eight steps have occurred. A step instant on that same edge is still applied.
- R7: A `frame_start` during the window restarts it. No step occurs on that edge, the step and strobe counts clear, and the next step falls QTR_CYCLES edges later.
- R8: Reset sets the code to 0. Before the first frame the flags and `bit_strobe` have no effect. The code is kept from one frame into the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_start | input | 1 | One-cycle pulse at the start of bit 0 of a frame |
| bit_strobe | input | 1 | One-cycle pulse at each following bit boundary |
| peak_low | input | 1 | Sensed peak is below the low threshold |
| peak_high | input | 1 | Sensed peak is above the high threshold |
| atten_code | output | CODE_W | Attenuation code, 3 dB per step |

## Verification
Each result is due on a known edge. With the frame edge as edge 0, the n-th step's new code is due right after edge n·QTR_CYCLES. A restart or window end takes effect on the edge that samples the pulse. The bench drives every input just after a falling edge and reads `atten_code` at the next falling edge. It keeps an edge index and a requirement-derived expected code, and compares on every cycle of the window and of the following hold period. A step that comes a cycle early or late therefore shows up as a mismatch on that exact cycle.

// File: rtl/alc_pkg.sv
package alc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ADAPT = 2'd1,
        ST_HOLD  = 2'd2
    } alc_state_e;

    typedef enum logic [1:0] {
        DIR_KEEP = 2'd0,
        DIR_UP   = 2'd1,
        DIR_DOWN = 2'd2
    } alc_dir_e;

    // High peak wins: more attenuation is the safe choice on conflict.
    function automatic alc_dir_e flags_to_dir(input logic below, input logic above);
        if (above)
            return DIR_UP;
        else if (below)
            return DIR_DOWN;
        else
            return DIR_KEEP;
    endfunction

endpackage

// File: rtl/alc_quarter_timer.sv
module alc_quarter_timer #(
    parameter int QTR_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    output logic tick
);
    localparam int TMR_W = $clog2(QTR_CYCLES + 1);
    localparam logic [TMR_W-1:0] LAST = TMR_W'(QTR_CYCLES - 1);

    logic [TMR_W-1:0] count;

    assign tick = run && (count == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            count <= '0;
        else if (clear)
            count <= '0;
        else if (run)
            count <= tick ? '0 : count + TMR_W'(1);
    end
endmodule

// File: rtl/alc_seq.sv
module alc_seq
    import alc_pkg::*;
#(
    parameter int STEPS       = 8,
    parameter int WINDOW_BITS = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frame_start,
    input  logic       bit_strobe,
    input  logic       tick,
    output logic       timer_clear,
    output logic       timer_run,
    output logic       step_apply,
    output alc_state_e state
);
    localparam int STEP_W = $clog2(STEPS + 1);
    localparam int WIN_W  = $clog2(WINDOW_BITS + 1);

    alc_state_e      next_state;
    logic [STEP_W-1:0] steps_done;
    logic [WIN_W-1:0]  strobes_seen;
    logic              last_step;
    logic              window_end;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= next_state;
    end

    // per-window counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            steps_done   <= '0;
            strobes_seen <= '0;
        end else if (frame_start) begin
            steps_done   <= '0;
            strobes_seen <= '0;
        end else if (state == ST_ADAPT) begin
            if (step_apply)
                steps_done <= steps_done + STEP_W'(1);
            if (bit_strobe)
                strobes_seen <= strobes_seen + WIN_W'(1);
        end
    end

    // outputs
    always_comb begin
        timer_clear = frame_start;
        timer_run   = (state == ST_ADAPT) && !frame_start;
        step_apply  = timer_run && tick;
        last_step   = step_apply && (steps_done == STEP_W'(STEPS - 1));
        window_end  = timer_run && bit_strobe && (strobes_seen == WIN_W'(WINDOW_BITS - 1));
    end

    // next state
    always_comb begin
        next_state = state;
        unique case (state)
            ST_IDLE:  if (frame_start) next_state = ST_ADAPT;
            ST_ADAPT: begin
                if (frame_start)
                    next_state = ST_ADAPT;
                else if (last_step || window_end)
                    next_state = ST_HOLD;
            end
            ST_HOLD:  if (frame_start) next_state = ST_ADAPT;
            default:  next_state = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/alc_atten_reg.sv
module alc_atten_reg
    import alc_pkg::*;
#(
    parameter int CODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              apply,
    input  alc_dir_e          dir,
    output logic [CODE_W-1:0] code
);
    localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            code <= '0;
        else if (apply) begin
            unique case (dir)
                DIR_UP:   if (code != CODE_MAX) code <= code + CODE_W'(1);
                DIR_DOWN: if (code != '0)       code <= code - CODE_W'(1);
                default:  code <= code;
            endcase
        end
    end
endmodule

// File: rtl/tx_alc_ctrl.sv
module tx_alc_ctrl
    import alc_pkg::*;
#(
    parameter int QTR_CYCLES  = 1000,
    parameter int STEPS       = 8,
    parameter int WINDOW_BITS = 2,
    parameter int CODE_W      = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              bit_strobe,
    input  logic              peak_low,
    input  logic              peak_high,
    output logic [CODE_W-1:0] atten_code
);
    logic       tmr_clear;
    logic       tmr_run;
    logic       tmr_tick;
    logic       step_apply;
    alc_state_e seq_state;
    alc_dir_e   step_dir;

    assign step_dir = flags_to_dir(peak_low, peak_high);

    alc_quarter_timer #(.QTR_CYCLES(QTR_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (tmr_clear),
        .run   (tmr_run),
        .tick  (tmr_tick)
    );

    alc_seq #(.STEPS(STEPS), .WINDOW_BITS(WINDOW_BITS)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .bit_strobe  (bit_strobe),
        .tick        (tmr_tick),
        .timer_clear (tmr_clear),
        .timer_run   (tmr_run),
        .step_apply  (step_apply),
        .state       (seq_state)
    );

    alc_atten_reg #(.CODE_W(CODE_W)) u_code (
        .clk   (clk),
        .rst_n (rst_n),
        .apply (step_apply),
        .dir   (step_dir),
        .code  (atten_code)
    );
endmodule

// File: rtl/tx_alc_ctrl_chk.sv
module tx_alc_ctrl_chk #(
    parameter int STEPS  = 8,
    parameter int CODE_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frame_start,
    input logic              peak_low,
    input logic              peak_high,
    input logic              step_apply,
    input logic [CODE_W-1:0] atten_code
);
    localparam int BC_W = $clog2(STEPS + 2);
    localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};

    logic [BC_W-1:0] burst_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            burst_cnt <= '0;
        else if (frame_start)
            burst_cnt <= '0;
        else if (step_apply)
            burst_cnt <= burst_cnt + BC_W'(1);
    end

    assert_only_on_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !step_apply |=> $stable(atten_code));

    assert_low_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (step_apply && peak_low && !peak_high && atten_code != '0)
        |=> atten_code == $past(atten_code) - CODE_W'(1));

    assert_floor_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (step_apply && !peak_high && atten_code == '0) |=> atten_code == '0);

    assert_high_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (step_apply && peak_high && atten_code != CODE_MAX)
        |=> atten_code == $past(atten_code) + CODE_W'(1));

    assert_ceiling_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (step_apply && peak_high && atten_code == CODE_MAX) |=> atten_code == CODE_MAX);

    assert_mid_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (step_apply && !peak_low && !peak_high) |=> $stable(atten_code));

    assert_burst_limit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        step_apply |-> burst_cnt < BC_W'(STEPS));

    assert_frame_edge_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> !step_apply);
endmodule

bind tx_alc_ctrl tx_alc_ctrl_chk #(.STEPS(STEPS), .CODE_W(CODE_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .peak_low    (peak_low),
    .peak_high   (peak_high),
    .step_apply  (step_apply),
    .atten_code  (atten_code)
);

// File: tb/sim_tx_alc_ctrl.sv
`timescale 1ns/1ps
module sim_tx_alc_ctrl;
    localparam int Q = 4;
    localparam int CW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          frame_start = 1'b0;
    logic          bit_strobe = 1'b0;
    logic          peak_low = 1'b0;
    logic          peak_high = 1'b0;
    logic [CW-1:0] atten_code;

    int total = 0;
    int bad = 0;
    int exp_code = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    tx_alc_ctrl #(.QTR_CYCLES(Q), .STEPS(8), .WINDOW_BITS(2), .CODE_W(CW)) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .bit_strobe  (bit_strobe),
        .peak_low    (peak_low),
        .peak_high   (peak_high),
        .atten_code  (atten_code)
    );

    task automatic check(input string tag, input int cyc);
        total++;
        if (int'(atten_code) != exp_code) begin
            bad++;
            $display("FAIL %s cycle %0d: atten_code actual=%0d expected=%0d",
                     tag, cyc, atten_code, exp_code);
        end
    endtask

    // frame_start, then max_m edges; strobes at edges sa and sb; flags per step index
    task automatic run_window(input logic [7:0] lo, input logic [7:0] hi,
                              input int sa, input int sb, input int max_m,
                              input string tag);
        bit active = 1'b1;
        int steps = 0;
        int scnt = 0;
        frame_start = 1'b1;
        bit_strobe  = 1'b0;
        @(negedge clk);
        frame_start = 1'b0;
        check(tag, 0);
        for (int m = 1; m <= max_m; m++) begin
            int n;
            bit was_active;
            n = (m - 1) / Q;
            if (n > 7) n = 7;
            peak_low   = lo[n];
            peak_high  = hi[n];
            bit_strobe = (m == sa) || (m == sb);
            @(negedge clk);
            was_active = active;
            if (was_active && (m % Q == 0)) begin
                int k;
                k = m / Q - 1;
                if (hi[k]) begin
                    if (exp_code < 7) exp_code++;
                end else if (lo[k]) begin
                    if (exp_code > 0) exp_code--;
                end
                steps++;
                if (steps == 8) active = 1'b0;
            end
            if (was_active && bit_strobe) begin
                scnt++;
                if (scnt == 2) active = 1'b0;
            end
            check(tag, m);
        end
        bit_strobe = 1'b0;
    endtask

    // no frame_start: flags and strobes toggle, code must stay put
    task automatic hold_check(input int ncyc, input string tag);
        for (int c = 0; c < ncyc; c++) begin
            peak_low   = c[0];
            peak_high  = c[1];
            bit_strobe = (c % 5 == 0);
            @(negedge clk);
            check(tag, c);
        end
        bit_strobe = 1'b0;
        peak_low   = 1'b0;
        peak_high  = 1'b0;
    endtask

    task automatic test_reset;
        exp_code = 0;
        check("R8 reset value", 0);
    endtask

    task automatic test_idle_ignored;
        hold_check(20, "R8 idle flags ignored");
    endtask

    task automatic test_floor;
        run_window(8'hFF, 8'h00, 4*Q, 8*Q, 8*Q + 6, "R2 floor saturation");
    endtask

    task automatic test_rise;
        run_window(8'h00, 8'hFF, 4*Q, 8*Q, 8*Q + 6, "R1 R3 rise and ceiling");
    endtask

    task automatic test_ceiling_both;
        run_window(8'hFF, 8'hFF, 4*Q, 8*Q, 8*Q + 4, "R3 both flags at ceiling");
    endtask

    task automatic test_mixed;
        run_window(8'hCF, 8'hC0, 4*Q, 8*Q, 8*Q + 4, "R2 R3 R4 mixed pattern");
        hold_check(30, "R5 hold after eight steps");
    endtask

    task automatic test_short_window;
        run_window(8'hFF, 8'h00, 2*Q, 3*Q + 1, 8*Q + 4, "R6 early window close");
        hold_check(20, "R6 hold after early close");
    endtask

    task automatic test_restart;
        run_window(8'h00, 8'hFF, 4*Q, 8*Q, 2*Q + 1, "R7 before restart");
        run_window(8'hFF, 8'h00, 4*Q, 8*Q, 8*Q + 4, "R7 after restart");
    endtask

    task automatic test_retain;
        run_window(8'h00, 8'h07, 4*Q, 8*Q, 8*Q + 2, "R8 set code");
        hold_check(10, "R8 between frames");
        run_window(8'h00, 8'h00, 4*Q, 8*Q, 8*Q + 2, "R8 retained into next frame");
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 150000);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_idle_ignored();
        test_floor();
        test_rise();
        test_ceiling_both();
        test_mixed();
        test_short_window();
        test_restart();
        test_retain();
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule